// File: doc/BRIEF.md
# Handshaked Packet Input Channel for an On-Chip Router

This block is one input port of a five-port on-chip router. A neighbouring router's output channel hands it whole 40-bit packets over a four-phase request/acknowledge handshake. Each packet is stored intact in a four-entry first-in first-out store. A local reader drains the store with a one-cycle read strobe. The depth is one less than the router's port count.

A small controller keeps separate write and read counts, three bits wide and wrapping modulo 8. It derives the empty and full flags from their difference. It also drops a ready flag for the cycle that follows any completed read or write, so the channel is seen as busy while an operation settles. The source and destination address fields of the oldest stored packet are brought out directly, so a route stage can inspect them before reading.

Packet layout: bits 39:37 hold the source address, bits 36:34 hold the destination address, and bits 33:0 hold the payload.

Top module: `nocin_channel`

## Requirements
- R1: A synchronous active-high reset leaves empty_o=1, full_o=0, ack_o=0, ready_o=1 and rd_valid_o=0.
- R2: When req_i is high, the handshake is idle, ready_o=1 and full_o=0, the packet on pkt_i is stored at that clock edge and ack_o reads 1 after it. ack_o stays 1 for as long as req_i stays high.
- R3: ack_o falls on the first edge that sees req_i low. Only one packet is stored per request/acknowledge cycle, however long req_i is held.
- R4: While full_o=1, a request is not acknowledged and nothing is stored.
- R5: A read strobe (rd_i=1 at an edge) with the store not empty puts the oldest packet on rd_data_o with rd_valid_o=1 in the following cycle. Packets leave in arrival order.
- R6: A read strobe while empty_o=1 is aborted: rd_valid_o=0 next cycle, and the flags and the stored contents are unchanged.
- R7: empty_o=1 when the write and read counts are equal. full_o=1 when writes exceed reads by four. Both are 0 for any occupancy in between.
- R8: ready_o is 0 in the cycle after an edge at which a write or a read was performed, and 1 otherwise.
- R9: head_src_o shows bits 39:37 and head_dst_o shows bits 36:34 of the oldest stored packet. Both are 0 when the store is empty.
- R10: The counts wrap modulo 8, and flags and ordering stay correct over runs longer than eight packets.
- R11: A write and a read at the same edge leave the occupancy unchanged and return the previous oldest packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request from the upstream sender |
| pkt_i | input | 40 | Packet offered by the sender |
| ack_o | output | 1 | Acknowledge to the sender |
| rd_i | input | 1 | Read strobe from the local reader |
| rd_data_o | output | 40 | Packet returned by the last accepted read |
| rd_valid_o | output | 1 | rd_data_o holds a packet read at the previous edge |
| empty_o | output | 1 | Store holds no packet |
| full_o | output | 1 | Store holds four packets |
| ready_o | output | 1 | Channel not busy with an operation |
| head_src_o | output | 3 | Source field of the oldest packet |
| head_dst_o | output | 3 | Destination field of the oldest packet |

## Verification
The handshake assertions assume a well-behaved sender: req_i stays high until ack_o has been seen, and falls before a new request starts. The bench keeps to this by raising req_i only while ack_o is low, waiting for acknowledge, then dropping req_i and waiting for ack_o to fall. The bench changes pkt_i only while req_i is low. Reads are assumed to be single-cycle strobes. The bench never holds rd_i across two edges, and it combines a read with a write only when the store is neither full nor empty.

// File: rtl/nocin_pkg.sv
package nocin_pkg;
  typedef enum logic [0:0] {
    IN_IDLE = 1'b0,
    IN_XFER = 1'b1
  } intake_st_t;
endpackage

// File: rtl/nocin_intake.sv
module nocin_intake
  import nocin_pkg::*;
#(
  parameter int PKT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             req_i,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             space_ok_i,
  output logic             ack_o,
  output logic             wr_fire_o,
  output logic [PKT_W-1:0] wr_pkt_o
);
  intake_st_t st_q;
  logic       ack_q;

  assign wr_fire_o = (st_q == IN_IDLE) && req_i && space_ok_i;
  assign wr_pkt_o  = pkt_i;
  assign ack_o     = ack_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= IN_IDLE;
      ack_q <= 1'b0;
    end else begin
      case (st_q)
        IN_IDLE: if (wr_fire_o) begin
          st_q  <= IN_XFER;
          ack_q <= 1'b1;
        end
        IN_XFER: if (!req_i) begin
          st_q  <= IN_IDLE;
          ack_q <= 1'b0;
        end
        default: begin
          st_q  <= IN_IDLE;
          ack_q <= 1'b0;
        end
      endcase
    end
  end

  // R2
  ack_after_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_fire_o |=> ack_o);
  // R2
  ack_held_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && req_i) |=> ack_o);
  // R3
  ack_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(ack_o) |-> !$past(req_i));
  // R3
  one_per_hs_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |-> !wr_fire_o);
endmodule

// File: rtl/nocin_store.sv
module nocin_store #(
  parameter int PKT_W = 40,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [PKT_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [PKT_W-1:0] rd_data_o
);
  logic [PKT_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_addr_i == AW'(g))) mem[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/nocin_ctrl.sv
module nocin_ctrl #(
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wr_fire_i,
  input  logic          rd_req_i,
  output logic          rd_fire_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ready_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] wcnt_q, rcnt_q, wcnt_d, rcnt_d;
  logic             empty_q, full_q, ready_q;

  function automatic logic [CNT_W-1:0] fill_level(input logic [CNT_W-1:0] w,
                                                  input logic [CNT_W-1:0] r);
    return w - r;
  endfunction

  function automatic logic is_full(input logic [CNT_W-1:0] w,
                                   input logic [CNT_W-1:0] r);
    return fill_level(w, r) == LIMIT;
  endfunction

  assign rd_fire_o = rd_req_i && !empty_q;
  assign wcnt_d    = wcnt_q + CNT_W'(wr_fire_i);
  assign rcnt_d    = rcnt_q + CNT_W'(rd_fire_o);
  assign wr_addr_o = wcnt_q[AW-1:0];
  assign rd_addr_o = rcnt_q[AW-1:0];
  assign empty_o   = empty_q;
  assign full_o    = full_q;
  assign ready_o   = ready_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      wcnt_q  <= wcnt_d;
      rcnt_q  <= rcnt_d;
      empty_q <= (wcnt_d == rcnt_d);
      full_q  <= is_full(wcnt_d, rcnt_d);
      ready_q <= !(wr_fire_i || rd_fire_o);
    end
  end

  // R7
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(empty_o && full_o));
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_fire_i |-> !full_o);
  // R6
  empty_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_req_i && empty_o && !wr_fire_i) |=> (empty_o && $stable(rcnt_q)));
  // R8
  busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_fire_i || rd_fire_o) |=> !ready_o);
  // R10
  level_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fill_level(wcnt_q, rcnt_q) <= LIMIT);
endmodule

// File: rtl/nocin_channel.sv
module nocin_channel #(
  parameter int PKT_W  = 40,
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic [PKT_W-1:0]  pkt_i,
  output logic              ack_o,
  input  logic              rd_i,
  output logic [PKT_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] head_src_o,
  output logic [ADDR_W-1:0] head_dst_o
);
  logic             wr_fire, rd_fire, space_ok;
  logic [PKT_W-1:0] wr_pkt, head_pkt;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [PKT_W-1:0] rd_data_q;
  logic             rd_valid_q;

  assign space_ok = ready_o && !full_o;

  nocin_intake #(.PKT_W(PKT_W)) u_intake (
    .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .pkt_i(pkt_i),
    .space_ok_i(space_ok), .ack_o(ack_o), .wr_fire_o(wr_fire), .wr_pkt_o(wr_pkt)
  );

  nocin_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .wr_fire_i(wr_fire), .rd_req_i(rd_i),
    .rd_fire_o(rd_fire), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .empty_o(empty_o), .full_o(full_o), .ready_o(ready_o)
  );

  nocin_store #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .wr_en_i(wr_fire), .wr_addr_i(wr_addr), .wr_data_i(wr_pkt),
    .rd_addr_i(rd_addr), .rd_data_o(head_pkt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_data_q <= head_pkt;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign head_src_o = empty_o ? '0 : head_pkt[PKT_W-1 -: ADDR_W];
  assign head_dst_o = empty_o ? '0 : head_pkt[PKT_W-1-ADDR_W -: ADDR_W];

  // R5
  read_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && !empty_o) |=> rd_valid_o);
  // R9
  head_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    empty_o |-> (head_src_o == '0 && head_dst_o == '0));
endmodule

// File: tb/test_nocin_channel.sv
module test_nocin_channel;
  logic        clk = 1'b0;
  logic        rst, req, rd;
  logic [39:0] pkt;
  logic        ack, rd_valid, empty, full, ready;
  logic [39:0] rd_data;
  logic [2:0]  hsrc, hdst;

  int n_chk = 0, n_bad = 0, seq = 0;
  logic [39:0] model [$];

  always #5 clk = ~clk;

  nocin_channel i_nocin_channel (
    .clk_i(clk), .rst_i(rst), .req_i(req), .pkt_i(pkt), .ack_o(ack),
    .rd_i(rd), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .empty_o(empty),
    .full_o(full), .ready_o(ready), .head_src_o(hsrc), .head_dst_o(hdst)
  );

  // op code (2 bits): 1 = push, 2 = pop, 3 = push and pop together; then expected occupancy (3 bits)
  localparam bit [4:0] VEC [17] = '{
    {2'd1,3'd1}, {2'd1,3'd2}, {2'd2,3'd1}, {2'd1,3'd2}, {2'd1,3'd3},
    {2'd1,3'd4}, {2'd1,3'd4}, {2'd2,3'd3}, {2'd3,3'd3}, {2'd3,3'd3},
    {2'd2,3'd2}, {2'd2,3'd1}, {2'd2,3'd0}, {2'd2,3'd0}, {2'd1,3'd1},
    {2'd3,3'd1}, {2'd2,3'd0}
  };

  function automatic logic [39:0] make_pkt(input int n);
    return {3'(n), 3'(n * 5 + 2), 34'(n * 40503 + 11)};
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check({"R7 empty ", tag}, 40'(empty), 40'(model.size() == 0));
    check({"R7 full ", tag}, 40'(full), 40'(model.size() == 4));
    if (model.size() == 0) begin
      check({"R9 src blank ", tag}, 40'(hsrc), 40'd0);
      check({"R9 dst blank ", tag}, 40'(hdst), 40'd0);
    end else begin
      check({"R9 src ", tag}, 40'(hsrc), 40'(model[0][39:37]));
      check({"R9 dst ", tag}, 40'(hdst), 40'(model[0][36:34]));
    end
  endtask

  task automatic do_push(input int hold);
    logic exp_acc;
    logic got;
    exp_acc = (model.size() < 4);
    pkt = make_pkt(seq);
    req = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      if (ack) begin got = 1'b1; break; end
    end
    if (exp_acc) check("R2 ack raised", 40'(got), 40'd1);
    else check("R4 no ack when full", 40'(got), 40'd0);
    if (got) begin
      check("R8 ready low after write", 40'(ready), 40'd0);
      for (int i = 0; i < hold; i++) begin
        @(posedge clk); @(negedge clk);
        check("R2 ack held", 40'(ack), 40'd1);
      end
      model.push_back(make_pkt(seq));
      seq++;
    end
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 ack falls", 40'(ack), 40'd0);
    check("R8 ready back", 40'(ready), 40'd1);
  endtask

  task automatic do_pop();
    logic exp_v;
    exp_v = (model.size() > 0);
    rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
    if (exp_v) begin
      check("R5 read valid", 40'(rd_valid), 40'd1);
      check("R5 read order", rd_data, model[0]);
      check("R8 ready low after read", 40'(ready), 40'd0);
      void'(model.pop_front());
    end else begin
      check("R6 empty read valid", 40'(rd_valid), 40'd0);
      check("R6 empty stays", 40'(empty), 40'd1);
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_both();
    logic [39:0] old;
    old = model[0];
    pkt = make_pkt(seq);
    req = 1'b1;
    rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
    check("R11 ack on joint op", 40'(ack), 40'd1);
    check("R11 read valid", 40'(rd_valid), 40'd1);
    check("R11 read data", rd_data, old);
    void'(model.pop_front());
    model.push_back(make_pkt(seq));
    seq++;
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 ack falls joint", 40'(ack), 40'd0);
  endtask

  task automatic check_reset();
    check("R1 empty", 40'(empty), 40'd1);
    check("R1 full", 40'(full), 40'd0);
    check("R1 ack", 40'(ack), 40'd0);
    check("R1 ready", 40'(ready), 40'd1);
    check("R1 rd_valid", 40'(rd_valid), 40'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 1'b0; rd = 1'b0; pkt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_reset();
    check_state("reset");

    foreach (VEC[k]) begin
      case (VEC[k][4:3])
        2'd1: do_push(k % 3);
        2'd2: do_pop();
        default: do_both();
      endcase
      check("R7 occupancy", 40'(model.size()), 40'(VEC[k][2:0]));
      check_state($sformatf("vec%0d", k));
    end

    // R10: long run across count wrap, occupancy cycling between 0 and 3
    for (int r = 0; r < 6; r++) begin
      do_push(0); do_push(1); do_push(0);
      check_state("R10 filled");
      do_pop(); do_pop(); do_pop();
      check_state("R10 drained");
    end

    // R3: one capture only while request is held long
    do_push(6);
    check("R3 single capture", 40'(model.size()), 40'd1);
    check_state("R3 long hold");

    // R1: reset with data stored
    do_push(0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model.delete();
    check_reset();
    check_state("R1 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule